// File: doc/BRIEF.md
# Serial Channel Control and Interrupt Registers

This block is the register and command front end of a four-channel serial controller. A processor reaches it over a simple 32-bit register bus. It keeps a global interrupt status register, an interrupt mask, and a packed enable mask that turns receive and transmit on or off for each channel. Each channel also has a CRC control register and a pair of clock shift and clock divide registers. A command register enables or disables a channel. Two command dialects are supported, chosen by a static input, and the two dialects use different disable opcodes.

The RX and TX ring engines send one-cycle set pulses into the status register and read back the decoded per-channel state: whether the channel is on, the TX and RX enables, the CRC length in bytes, and the bit clock rate. The rate comes from a sequential divider. A flag shows when the rate is valid. A single level interrupt output reports pending masked status. It is released only after several quiet updates in a row, which keeps it from chattering.

The request side is a valid-only interface and has no back-pressure. A request is taken in every cycle in which `req_valid` is high. A read returns its data with `rsp_valid` exactly one cycle later. A write produces no response.

Top module: `sercc_regs`

## Requirements
- R1: The enable mask register is at address 0x14. Channel n uses bits 2n+1:2n of this register. Bit 2n drives `tx_en[n]` and bit 2n+1 drives `rx_en[n]`. The register reads back the value written.
- R2: In the status register at 0x00, a pulse on `tx_done_set[n]` sets bit n and a pulse on `rx_frame_set[n]` sets bit 4+n. A write to 0x00 clears exactly the bits that are one in the written data.
- R3: The mask register is at 0x10. After any update (a status write, a mask write, or a set pulse) that leaves status AND mask nonzero, `irq` is high from the next cycle.
- R4: When status AND mask is zero, `irq` falls only on the third update in a row that leaves no masked bit pending. An update with a masked bit pending restarts this count.
- R5: A channel's rate is (8064000 >> shift) / (divide + 1), with a shift of 8 treated as 0. `rate_valid[n]` rises when the divider finishes.
- R6: A recomputation starts on any write or read of the channel's shift register (channel offset 0x40). A write to the divide register (offset 0x44) alone leaves the published rate unchanged.
- R7: When the CRC control register (channel offset 0x00) holds 0x0A, `crc_bytes` for that channel is 4. For 0x08, or for any other value, it is 2. The register reads back the value written.
- R8: A command write to 0x2C24 takes the opcode from bits 19:12 and the channel from bits 1:0. Opcode 0x00 turns the channel on in both dialects. With `dialect`=0, opcode 0x10 turns it off.
- R9: With `dialect`=1, opcodes 0x30 and 0x50 turn the channel off.
- R10: Any other opcode, including the disable opcode of the other dialect, leaves `chan_on` unchanged.
- R11: A read of 0x2C2C returns 0x0000FFFF. A read of an unimplemented address returns zero.
- R12: `rsp_valid` is high exactly in the cycle after an accepted read, and never after a write.
- Channel n's registers are in the 0x100-byte window starting at 0x100*(n+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dialect | input | 1 | Command dialect select (0 or 1) |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| tx_done_set | input | 4 | TX completion set pulses, one per channel |
| rx_frame_set | input | 4 | RX frame set pulses, one per channel |
| irq | output | 1 | Level interrupt |
| chan_on | output | 4 | Channel enabled by command |
| tx_en | output | 4 | TX enable per channel |
| rx_en | output | 4 | RX enable per channel |
| crc_bytes | output | 12 | CRC length per channel, 3 bits each |
| chan_rate | output | 96 | Bit clock rate per channel, 24 bits each |
| rate_valid | output | 4 | Rate result valid per channel |

## Verification
The interrupt path is tested with set pulses that land under the mask and outside it, with clears, and with mask rewrites. These sequences separate a release on the first or second quiet update from the correct third one, and check that a pending update in the middle restarts the count. The rate divider is tested with a zero divide, a shift of 8, a full-range divide and a mixed case. A separate step writes only the divide register and then reads the shift register, which shows whether the recomputation is triggered by the right access. Commands are sent under both dialects, and each dialect also receives the other dialect's disable opcode, so a decoder that mixes the two opcode sets is detected.

// File: rtl/sercc_pkg.sv
package sercc_pkg;
  localparam logic [15:0] A_STATUS  = 16'h0000;
  localparam logic [15:0] A_MASK    = 16'h0010;
  localparam logic [15:0] A_ENABLE  = 16'h0014;
  localparam logic [15:0] A_CMD     = 16'h2C24;
  localparam logic [15:0] A_CMDRSP  = 16'h2C2C;
  localparam logic [7:0]  O_CRC     = 8'h00;
  localparam logic [7:0]  O_SHIFT   = 8'h40;
  localparam logic [7:0]  O_DIV     = 8'h44;
  localparam logic [7:0]  OP_ON     = 8'h00;
  localparam logic [7:0]  OP_OFF_D0 = 8'h10;
  localparam logic [7:0]  OP_OFF_D1A = 8'h30;
  localparam logic [7:0]  OP_OFF_D1B = 8'h50;
  localparam logic [31:0] RSP_OK    = 32'h0000_FFFF;
  localparam int unsigned BASE_RATE = 8064000;
endpackage

// File: rtl/sercc_ratediv.sv
module sercc_ratediv #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo_o,
  output logic             valid_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int PW    = NUM_W + DEN_W;

  logic             busy, valid;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W-1:0] rem, den_l;
  logic [NUM_W-1:0] quo, num_l;
  logic [DEN_W:0]   trial, diff;
  logic             fits;

  always_comb begin
    trial = {rem, quo[NUM_W-1]};
    fits  = trial >= {1'b0, den_l};
    diff  = trial - {1'b0, den_l};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; valid <= 1'b0; cnt <= '0;
      rem <= '0; quo <= '0; num_l <= '0; den_l <= DEN_W'(1);
    end else if (start) begin
      busy <= 1'b1; valid <= 1'b0; cnt <= '0;
      rem <= '0; quo <= num; num_l <= num; den_l <= den;
    end else if (busy) begin
      rem <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      quo <= {quo[NUM_W-2:0], fits};
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(NUM_W - 1)) begin
        busy  <= 1'b0;
        valid <= 1'b1;
      end
    end
  end

  assign quo_o   = valid ? quo : '0;
  assign valid_o = valid;

  assert_busy_not_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !valid);
  assert_quotient_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((PW'(quo) * PW'(den_l) <= PW'(num_l)) &&
               (PW'(num_l) - PW'(quo) * PW'(den_l) < PW'(den_l))));
endmodule

// File: rtl/sercc_irq.sv
module sercc_irq #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   set_tx,
  input  logic [NCH-1:0]   set_rx,
  input  logic             st_we,
  input  logic             mask_we,
  input  logic [2*NCH-1:0] wdata,
  output logic [2*NCH-1:0] status_o,
  output logic [2*NCH-1:0] mask_o,
  output logic             irq_o
);
  localparam int ST_W = 2 * NCH;

  logic [ST_W-1:0] status_q, mask_q, sets, st_n, mask_n;
  logic [1:0]      quiet_q;
  logic            irq_q, upd, pend;

  always_comb begin
    sets   = {set_rx, set_tx};
    st_n   = (status_q & ~(st_we ? wdata : '0)) | sets;
    mask_n = mask_we ? wdata : mask_q;
    upd    = st_we | mask_we | (|sets);
    pend   = |(st_n & mask_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0; mask_q <= '0; quiet_q <= '0; irq_q <= 1'b0;
    end else begin
      status_q <= st_n;
      mask_q   <= mask_n;
      if (upd) begin
        if (pend) begin
          irq_q   <= 1'b1;
          quiet_q <= '0;
        end else if (quiet_q == 2'd2) begin
          irq_q   <= 1'b0;
          quiet_q <= '0;
        end else begin
          quiet_q <= quiet_q + 1'b1;
        end
      end
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  assert_irq_when_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & mask_q) != '0) |-> irq_q);
  assert_irq_fall_on_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(upd));
  assert_status_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/sercc_cmd.sv
module sercc_cmd #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dialect,
  input  logic                   cmd_we,
  input  logic [7:0]             opcode,
  input  logic [$clog2(NCH)-1:0] chan,
  output logic [NCH-1:0]         on_o
);
  import sercc_pkg::*;

  logic [NCH-1:0] on_q;
  logic           is_on, is_off, known;

  always_comb begin
    is_on  = opcode == OP_ON;
    is_off = dialect ? (opcode == OP_OFF_D1A || opcode == OP_OFF_D1B)
                     : (opcode == OP_OFF_D0);
    known  = is_on | is_off;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) on_q <= '0;
    else if (cmd_we && known && (int'(chan) < NCH)) on_q[chan] <= is_on;
  end

  assign on_o = on_q;

  assert_ignored_opcode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && opcode != OP_ON && opcode != OP_OFF_D0 && opcode != OP_OFF_D1A &&
     opcode != OP_OFF_D1B) |=> $stable(on_q));
  assert_off_dialect0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !dialect && opcode == OP_OFF_D0) |=> !on_q[$past(chan)]);
endmodule

// File: rtl/sercc_chan.sv
module sercc_chan #(
  parameter int SHIFT_W = 5,
  parameter int DIV_W   = 8,
  parameter int RATE_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               crc_we,
  input  logic               shift_we,
  input  logic               shift_re,
  input  logic               div_we,
  input  logic [31:0]        wdata,
  output logic [31:0]        crc_ctrl_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [DIV_W-1:0]   div_o,
  output logic [2:0]         crc_bytes_o,
  output logic [RATE_W-1:0]  rate_o,
  output logic               valid_o
);
  import sercc_pkg::*;

  logic [31:0]        crc_q;
  logic [SHIFT_W-1:0] shift_q, shift_src, shift_eff;
  logic [DIV_W-1:0]   div_q;
  logic [RATE_W-1:0]  num;
  logic [DIV_W:0]     den;
  logic               start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= '0; shift_q <= '0; div_q <= '0;
    end else begin
      if (crc_we)   crc_q   <= wdata;
      if (shift_we) shift_q <= wdata[SHIFT_W-1:0];
      if (div_we)   div_q   <= wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    shift_src = shift_we ? wdata[SHIFT_W-1:0] : shift_q;
    shift_eff = (shift_src == SHIFT_W'(8)) ? '0 : shift_src;
    num       = RATE_W'(BASE_RATE) >> shift_eff;
    den       = {1'b0, div_q} + 1'b1;
    start     = shift_we | shift_re;
    crc_bytes_o = (crc_q == 32'h0000_000A) ? 3'd4 : 3'd2;
  end

  sercc_ratediv #(.NUM_W(RATE_W), .DEN_W(DIV_W + 1)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .num(num), .den(den),
    .quo_o(rate_o), .valid_o(valid_o)
  );

  assign crc_ctrl_o = crc_q;
  assign shift_o    = shift_q;
  assign div_o      = div_q;

  assert_crc_len_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_bytes_o == 3'd2) || (crc_bytes_o == 3'd4));
  assert_div_write_keeps_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_we && valid_o && !start) |=> ($stable(rate_o) && valid_o));
endmodule

// File: rtl/sercc_regs.sv
module sercc_regs #(
  parameter int NCH     = 4,
  parameter int SHIFT_W = 5,
  parameter int DIV_W   = 8,
  parameter int RATE_W  = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dialect,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [15:0]           req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata,
  input  logic [NCH-1:0]        tx_done_set,
  input  logic [NCH-1:0]        rx_frame_set,
  output logic                  irq,
  output logic [NCH-1:0]        chan_on,
  output logic [NCH-1:0]        tx_en,
  output logic [NCH-1:0]        rx_en,
  output logic [NCH*3-1:0]      crc_bytes,
  output logic [NCH*RATE_W-1:0] chan_rate,
  output logic [NCH-1:0]        rate_valid
);
  import sercc_pkg::*;

  localparam int ST_W = 2 * NCH;
  localparam int CH_W = $clog2(NCH);

  logic            wr, rd;
  logic [7:0]      win, offs;
  logic            in_chan;
  logic [7:0]      chan_idx;
  logic [ST_W-1:0] status, mask, en_q;
  logic [31:0]     rd_mux, rdata_q;
  logic            rvalid_q;

  logic [31:0]        crc_a   [NCH];
  logic [SHIFT_W-1:0] shift_a [NCH];
  logic [DIV_W-1:0]   div_a   [NCH];

  always_comb begin
    wr       = req_valid & req_write;
    rd       = req_valid & ~req_write;
    win      = req_addr[15:8];
    offs     = req_addr[7:0];
    in_chan  = (win >= 8'd1) && (int'(win) <= NCH);
    chan_idx = win - 8'd1;
  end

  sercc_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_tx(tx_done_set), .set_rx(rx_frame_set),
    .st_we(wr && req_addr == A_STATUS), .mask_we(wr && req_addr == A_MASK),
    .wdata(req_wdata[ST_W-1:0]), .status_o(status), .mask_o(mask), .irq_o(irq)
  );

  sercc_cmd #(.NCH(NCH)) u_cmd (
    .clk(clk), .rst_n(rst_n), .dialect(dialect),
    .cmd_we(wr && req_addr == A_CMD), .opcode(req_wdata[19:12]),
    .chan(req_wdata[CH_W-1:0]), .on_o(chan_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (wr && req_addr == A_ENABLE) en_q <= req_wdata[ST_W-1:0];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    assign hit = in_chan && (int'(chan_idx) == n);
    assign tx_en[n] = en_q[2*n];
    assign rx_en[n] = en_q[2*n+1];

    sercc_chan #(.SHIFT_W(SHIFT_W), .DIV_W(DIV_W), .RATE_W(RATE_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .crc_we(wr && hit && offs == O_CRC),
      .shift_we(wr && hit && offs == O_SHIFT),
      .shift_re(rd && hit && offs == O_SHIFT),
      .div_we(wr && hit && offs == O_DIV),
      .wdata(req_wdata),
      .crc_ctrl_o(crc_a[n]), .shift_o(shift_a[n]), .div_o(div_a[n]),
      .crc_bytes_o(crc_bytes[3*n +: 3]),
      .rate_o(chan_rate[RATE_W*n +: RATE_W]),
      .valid_o(rate_valid[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (in_chan) begin
      for (int n = 0; n < NCH; n++) begin
        if (int'(chan_idx) == n) begin
          case (offs)
            O_CRC:   rd_mux = crc_a[n];
            O_SHIFT: rd_mux = 32'(shift_a[n]);
            O_DIV:   rd_mux = 32'(div_a[n]);
            default: rd_mux = '0;
          endcase
        end
      end
    end else begin
      case (req_addr)
        A_STATUS: rd_mux = 32'(status);
        A_MASK:   rd_mux = 32'(mask);
        A_ENABLE: rd_mux = 32'(en_q);
        A_CMDRSP: rd_mux = RSP_OK;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0; rdata_q <= '0;
    end else begin
      rvalid_q <= rd;
      rdata_q  <= rd ? rd_mux : '0;
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;

  assert_rsp_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  assert_rsp_for_each_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_enable_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_ENABLE) |=> (tx_en[0] == $past(req_wdata[0]) &&
                                      rx_en[0] == $past(req_wdata[1])));
endmodule

// File: tb/sercc_regs_test.sv
module sercc_regs_test;
  localparam int NCH = 4;
  localparam int RW  = 24;

  logic clk = 0, rst_n = 0, dialect = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NCH-1:0] tx_done_set = '0, rx_frame_set = '0;
  logic irq;
  logic [NCH-1:0] chan_on, tx_en, rx_en, rate_valid;
  logic [NCH*3-1:0] crc_bytes;
  logic [NCH*RW-1:0] chan_rate;

  sercc_regs uut (
    .clk(clk), .rst_n(rst_n), .dialect(dialect), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tx_done_set(tx_done_set),
    .rx_frame_set(rx_frame_set), .irq(irq), .chan_on(chan_on), .tx_en(tx_en),
    .rx_en(rx_en), .crc_bytes(crc_bytes), .chan_rate(chan_rate),
    .rate_valid(rate_valid)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R12 unexpected response", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pulse(input logic [3:0] tx, input logic [3:0] rx);
    @(negedge clk);
    tx_done_set = tx; rx_frame_set = rx;
    @(negedge clk);
    tx_done_set = '0; rx_frame_set = '0;
  endtask

  function automatic logic [31:0] exp_rate(input int sh, input int dv);
    int s = (sh == 8) ? 0 : sh;
    return 32'((8064000 >> s) / (dv + 1));
  endfunction

  task automatic rate_chk(input int ch, input int sh, input int dv, input string tag);
    for (int i = 0; i < 60 && !rate_valid[ch]; i++) @(negedge clk);
    chk({tag, " valid"}, 32'(rate_valid[ch]), 32'h1);
    chk(tag, 32'(chan_rate[RW*ch +: RW]), exp_rate(sh, dv));
  endtask

  function automatic logic [15:0] ca(input int ch, input logic [7:0] off);
    return 16'((ch + 1) * 256) | 16'(off);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset irq R3", 32'(irq), 0);
    chk("reset chan_on R8", 32'(chan_on), 0);
    chk("reset rate_valid R5", 32'(rate_valid), 0);
    rd(16'h0000, 0, "reset status R2");

    // R1 enable fields
    wr(16'h0014, 32'h93);
    chk("R1 tx_en", 32'(tx_en), 32'h5);
    chk("R1 rx_en", 32'(rx_en), 32'h9);
    rd(16'h0014, 32'h93, "R1 readback");

    // R2/R3/R4 interrupt
    pulse(4'h0, 4'h4);
    chk("R3 unmasked no irq", 32'(irq), 0);
    rd(16'h0000, 32'h40, "R2 rx bit 4+n");
    wr(16'h0010, 32'h40);
    chk("R3 irq on mask", 32'(irq), 1);
    pulse(4'h2, 4'h0);
    rd(16'h0000, 32'h42, "R2 tx bit n");
    wr(16'h0000, 32'h40);
    chk("R4 quiet 1 holds", 32'(irq), 1);
    rd(16'h0000, 32'h02, "R2 w1c");
    wr(16'h0010, 32'h40);
    chk("R4 quiet 2 holds", 32'(irq), 1);
    pulse(4'h8, 4'h0);
    chk("R4 quiet 3 releases", 32'(irq), 0);
    wr(16'h0010, 32'h08);
    chk("R3 pending via mask", 32'(irq), 1);
    wr(16'h0000, 32'h08);
    pulse(4'h0, 4'h1);
    chk("R4 two quiet hold", 32'(irq), 1);
    wr(16'h0010, 32'h10);
    chk("R4 pending restarts", 32'(irq), 1);
    wr(16'h0000, 32'h10);
    wr(16'h0010, 32'h10);
    chk("R4 count restarted", 32'(irq), 1);
    wr(16'h0010, 32'h10);
    chk("R4 third quiet after restart", 32'(irq), 0);

    // R7 CRC size
    wr(ca(1, 8'h00), 32'h0A);
    chk("R7 0x0A gives 4", 32'(crc_bytes[5:3]), 4);
    wr(ca(1, 8'h00), 32'h08);
    chk("R7 0x08 gives 2", 32'(crc_bytes[5:3]), 2);
    wr(ca(2, 8'h00), 32'h0C);
    chk("R7 other gives 2", 32'(crc_bytes[8:6]), 2);
    rd(ca(1, 8'h00), 32'h08, "R7 readback");

    // R5 rates
    wr(ca(0, 8'h44), 0);
    wr(ca(0, 8'h40), 0);
    rate_chk(0, 0, 0, "R5 shift0 div0");
    wr(ca(0, 8'h40), 8);
    rate_chk(0, 8, 0, "R5 shift8 alias");
    wr(ca(3, 8'h44), 6);
    wr(ca(3, 8'h40), 2);
    rate_chk(3, 2, 6, "R5 shift2 div6");
    wr(ca(2, 8'h44), 255);
    wr(ca(2, 8'h40), 3);
    rate_chk(2, 3, 255, "R5 div255");

    // R6 divide write alone keeps rate; shift read recomputes
    wr(ca(3, 8'h44), 1);
    repeat (30) @(negedge clk);
    chk("R6 div write keeps rate", 32'(chan_rate[RW*3 +: RW]), exp_rate(2, 6));
    rd(ca(3, 8'h40), 2, "R6 shift readback");
    rate_chk(3, 2, 1, "R6 recompute on read");

    // R8/R10 dialect 0
    dialect = 0;
    wr(16'h2C24, 32'h0000_0002);
    chk("R8 enable", 32'(chan_on), 32'h4);
    wr(16'h2C24, 32'h0003_0002);
    chk("R10 0x30 ignored in d0", 32'(chan_on), 32'h4);
    wr(16'h2C24, 32'h0001_0002);
    chk("R8 0x10 disables", 32'(chan_on), 32'h0);

    // R9/R10 dialect 1
    dialect = 1;
    wr(16'h2C24, 32'h0000_0002);
    wr(16'h2C24, 32'h0000_0001);
    wr(16'h2C24, 32'h0001_0002);
    chk("R10 0x10 ignored in d1", 32'(chan_on), 32'h6);
    wr(16'h2C24, 32'h0007_0001);
    chk("R10 unknown opcode", 32'(chan_on), 32'h6);
    wr(16'h2C24, 32'h0003_0002);
    chk("R9 0x30 disables", 32'(chan_on), 32'h2);
    wr(16'h2C24, 32'h0005_0001);
    chk("R9 0x50 disables", 32'(chan_on), 32'h0);

    // R11 fixed reads
    rd(16'h2C2C, 32'h0000_FFFF, "R11 response reg");
    rd(ca(1, 8'h60), 0, "R11 unmapped channel offset");
    rd(16'h3000, 0, "R11 unmapped global");
    rd(16'h2C24, 0, "R11 command reads zero");

    // R12 writes give no response, all reads answered
    wr(16'h0010, 0);
    chk("R12 no response after write", 32'(rsp_valid), 0);
    @(negedge clk);
    chk("R12 all reads answered", 32'(exp_q.size()), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule